// File: doc/BRIEF.md
# Serial PHY Management Master

This block is a host-programmed master for the two-wire PHY management bus (MDC clock, MDIO data). Software programs a clock divider and preamble option, loads a PHY address, a register address and write data, and then writes a one-hot command word. The block serialises a clause-22 read or write frame on the bus, reports progress through a busy flag, and places the returned word of a read in a receive-data register.

A scan command turns the block into a poller: it reads the same PHY register over and over, with one idle system clock between frames. After every scan read it refreshes a link-fail flag from bit 2 of the returned word. A data-invalid flag tells software that no scan result exists yet. Scanning stops at the end of the frame in progress once software clears the scan bit.

The host side is a simple word-select register port: writes take effect on the clock edge, and read data is combinational from the select lines.

Top module: `mdio_mgmt`

## Requirements
- R1: The register select busAddr picks the register as follows: 0 = mode, 1 = command, 2 = address, 3 = transmit data, 4 = receive data (read-only), 5 = status (read-only). Every register reads as zero after reset, and MDC and the MDIO drive enable are low after reset.
- R2: In the mode register, bits 7:0 hold the clock divider and bit 8 suppresses the preamble. Bit 0 of the divider always reads back as 0, so a write of 0x1FF reads back as 0x1FE.
- R3: While a frame runs, MDC stays high for divider/2 system clocks and low for divider/2 system clocks. A divider of 0 behaves as 2. MDC is low and MDIO is undriven whenever busy is clear.
- R4: A write frame is driven for its whole length, MSB first: 32 one bits of preamble, start 01, opcode 01, the PHY address (address register bits 4:0), the register address (bits 12:8), turnaround 10, then the 16 bits of transmit data. The line changes only while MDC is low.
- R5: When mode bit 8 is set, the frame begins directly with the start bits and has no preamble.
- R6: A read frame uses opcode 10. The MDIO drive enable is released for the two turnaround bits and the 16 data bits. Data is sampled on the rising MDC edges and lands in the receive data register (bits 15:0) when the frame ends. A PHY that does not answer returns 0xFFFF.
- R7: In the command register, bit 2 is write, bit 1 is read and bit 0 is scan, with priority write over read over scan. A nonzero command written while idle sets status bit 1 (busy) on the next clock, and busy stays set until the frame ends.
- R8: A command written while busy starts no frame, either at once or after the current frame. Changing the address or transmit data registers during a frame does not alter that frame.
- R9: In scan mode, read frames repeat while command bit 0 stays set, and busy stays high between them. After software clears bit 0, the frame in progress completes, busy drops and no further frame starts.
- R10: Starting a scan sets status bit 2 (invalid). Invalid clears when the first scan read completes. After each scan read, status bit 0 (link fail) equals the inverse of bit 2 of the returned word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register select |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Value driven onto the management data line |
| mdioOe | output | 1 | Drive enable for the management data line |
| mdioIn | input | 1 | Sampled level of the management data line |

## Verification
A wrong bit counter or shift register shows up within one frame as a preamble of the wrong length, misplaced address fields or a corrupted data word at the bench's PHY model. A wrong drive-enable window shows on the very rising edge where the turnaround starts. A corrupted busy or scan state shows at the ports as an extra frame, a missing frame, or busy dropping between scan frames. The monitor catches an extra or missing frame within a few hundred clocks. A wrong status flag shows up at the first status read after the scan frame that should have set it.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int BUS_W   = 32;
  localparam int SEL_W   = 3;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;
  localparam int DIV_W   = 8;
  localparam int HALF_W  = DIV_W - 1;
  localparam int CMD_W   = 3;

  localparam logic [SEL_W-1:0] SEL_MODE = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CMD  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ADDR = 3'd2;
  localparam logic [SEL_W-1:0] SEL_TXD  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_RXD  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd5;

  // strobe and frame parameters from control to datapath
  typedef struct packed {
    logic              start;
    logic              isRead;
    logic              noPre;
    logic [HALF_W-1:0] half;
    logic [ADDR_W-1:0] phyAd;
    logic [ADDR_W-1:0] regAd;
    logic [DATA_W-1:0] wdata;
  } launch_t;
endpackage

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [SEL_W-1:0]  busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output launch_t           launch,
  input  logic              frameDone,
  input  logic [DATA_W-1:0] rxWord,
  output logic              busy
);
  logic [HALF_W-1:0] divHiQ;
  logic              noPreQ;
  logic [CMD_W-1:0]  cmdQ;
  logic [ADDR_W-1:0] phyQ, regQ;
  logic [DATA_W-1:0] txQ, rxQ;
  logic              linkFailQ, busyQ, invalidQ, scanCurQ, readCurQ;

  logic unusedBits;
  assign unusedBits = ^{busWdata[BUS_W-1:13], busWdata[7:5]};

  logic cmdWr, hostGo, scanAgain, hostScan;
  assign cmdWr     = busWr && (busAddr == SEL_CMD);
  assign hostGo    = cmdWr && !busyQ && (busWdata[CMD_W-1:0] != '0);
  assign hostScan  = !busWdata[2] && !busWdata[1];
  assign scanAgain = frameDone && scanCurQ && cmdQ[0];

  always_comb begin
    launch.start  = hostGo || scanAgain;
    launch.isRead = scanAgain ? 1'b1 : !busWdata[2];
    launch.noPre  = noPreQ;
    launch.half   = (divHiQ == '0) ? HALF_W'(1) : divHiQ;
    launch.phyAd  = phyQ;
    launch.regAd  = regQ;
    launch.wdata  = txQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divHiQ <= '0; noPreQ <= 1'b0; cmdQ <= '0;
      phyQ <= '0; regQ <= '0; txQ <= '0; rxQ <= '0;
      linkFailQ <= 1'b0; busyQ <= 1'b0; invalidQ <= 1'b0;
      scanCurQ <= 1'b0; readCurQ <= 1'b0;
    end else begin
      if (busWr) begin
        unique case (busAddr)
          SEL_MODE: begin divHiQ <= busWdata[DIV_W-1:1]; noPreQ <= busWdata[8]; end
          SEL_CMD:  cmdQ <= busWdata[CMD_W-1:0];
          SEL_ADDR: begin phyQ <= busWdata[4:0]; regQ <= busWdata[12:8]; end
          SEL_TXD:  txQ <= busWdata[DATA_W-1:0];
          default:  ;
        endcase
      end
      if (launch.start) busyQ <= 1'b1;
      else if (frameDone) busyQ <= 1'b0;
      if (hostGo) begin
        scanCurQ <= hostScan;
        readCurQ <= !busWdata[2];
        if (hostScan) invalidQ <= 1'b1;
      end
      if (frameDone) begin
        if (readCurQ) rxQ <= rxWord;
        if (scanCurQ) begin
          linkFailQ <= !rxWord[2];
          invalidQ  <= 1'b0;
        end
      end
    end
  end

  assign busy = busyQ;

  always_comb begin
    unique case (busAddr)
      SEL_MODE: busRdata = {23'd0, noPreQ, divHiQ, 1'b0};
      SEL_CMD:  busRdata = {29'd0, cmdQ};
      SEL_ADDR: busRdata = {19'd0, regQ, 3'd0, phyQ};
      SEL_TXD:  busRdata = {16'd0, txQ};
      SEL_RXD:  busRdata = {16'd0, rxQ};
      SEL_STAT: busRdata = {29'd0, invalidQ, busyQ, linkFailQ};
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_dp.sv
module mdio_mgmt_dp
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  launch_t           launch,
  input  logic              mdioIn,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              frameDone,
  output logic [DATA_W-1:0] rxWord
);
  localparam int TAIL_W  = 2 + DATA_W;
  localparam int FRAME_W = 4 + 2 * ADDR_W + TAIL_W;
  localparam int SR_W    = PRE_W + FRAME_W;
  localparam int CNT_W   = $clog2(SR_W + 1);

  logic [SR_W-1:0]   srQ;
  logic [CNT_W-1:0]  leftQ;
  logic [HALF_W-1:0] halfQ, phaseQ;
  logic              mdcQ, activeQ, readQ, doneQ;
  logic [DATA_W-1:0] rxQ;

  logic [FRAME_W-1:0] frameBits;
  assign frameBits = {2'b01,
                      launch.isRead ? 2'b10 : 2'b01,
                      launch.phyAd, launch.regAd,
                      launch.isRead ? 2'b11 : 2'b10,
                      launch.isRead ? {DATA_W{1'b1}} : launch.wdata};

  logic phaseEnd;
  assign phaseEnd = (phaseQ == halfQ - HALF_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srQ <= '0; leftQ <= '0; halfQ <= HALF_W'(1); phaseQ <= '0;
      mdcQ <= 1'b0; activeQ <= 1'b0; readQ <= 1'b0; doneQ <= 1'b0; rxQ <= '0;
    end else begin
      doneQ <= 1'b0;
      if (launch.start) begin
        srQ     <= launch.noPre ? {frameBits, {PRE_W{1'b0}}} : {{PRE_W{1'b1}}, frameBits};
        leftQ   <= launch.noPre ? CNT_W'(FRAME_W) : CNT_W'(SR_W);
        halfQ   <= launch.half;
        phaseQ  <= '0;
        mdcQ    <= 1'b0;
        activeQ <= 1'b1;
        readQ   <= launch.isRead;
      end else if (activeQ) begin
        if (phaseEnd) begin
          phaseQ <= '0;
          if (!mdcQ) begin
            mdcQ <= 1'b1;
            if (readQ && leftQ <= CNT_W'(DATA_W)) rxQ <= {rxQ[DATA_W-2:0], mdioIn};
          end else begin
            mdcQ  <= 1'b0;
            srQ   <= srQ << 1;
            leftQ <= leftQ - CNT_W'(1);
            if (leftQ == CNT_W'(1)) begin
              activeQ <= 1'b0;
              doneQ   <= 1'b1;
            end
          end
        end else begin
          phaseQ <= phaseQ + HALF_W'(1);
        end
      end
    end
  end

  assign mdc       = mdcQ;
  assign mdioOut   = srQ[SR_W-1];
  assign mdioOe    = activeQ && (!readQ || leftQ > CNT_W'(TAIL_W));
  assign frameDone = doneQ;
  assign rxWord    = rxQ;
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [SEL_W-1:0] busAddr,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn
);
  launch_t           launchW;
  logic              doneW, busyW;
  logic [DATA_W-1:0] rxWordW;

  mdio_mgmt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .launch(launchW),
    .frameDone(doneW), .rxWord(rxWordW), .busy(busyW)
  );

  mdio_mgmt_dp #(.PRE_W(32)) u_dp (
    .clk(clk), .rstN(rstN), .launch(launchW), .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .frameDone(doneW), .rxWord(rxWordW)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busWr,
  input logic [2:0] busAddr,
  input logic [2:0] cmdBits,
  input logic       mdc,
  input logic       mdioOut,
  input logic       mdioOe,
  input logic       busy,
  input logic       frameDone,
  input logic       launchStart
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe)); // R3

  AST_RISE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> ($stable(mdioOut) && $stable(mdioOe))); // R6

  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !frameDone) |-> !launchStart); // R8

  AST_BUSY_ON_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd1 && cmdBits != 3'd0 && !busy) |=> busy); // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !launchStart) |=> !busy); // R7
endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .cmdBits(busWdata[2:0]), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .busy(busyW), .frameDone(doneW), .launchStart(launchW.start)
);

// File: tb/mdio_mgmt_test.sv
module mdio_mgmt_test;
  import mdio_mgmt_pkg::*;

  localparam logic [4:0] PHY_ID = 5'd3;

  typedef struct packed {
    logic        isRead;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] data;
    logic [5:0]  preLen;
  } frm_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        mdc, mdioOut, mdioOe, mdioIn;
  logic        phyDrive = 1'b1;
  assign mdioIn = mdioOe ? mdioOut : phyDrive;

  mdio_mgmt uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int checks = 0;
  int fails = 0;
  int curHalf = 1;
  int curPre = 32;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // PHY model and scoreboard monitor
  logic [15:0] phyMem [32];
  frm_t expQ[$];
  frm_t scanExp;
  bit   scanOn = 1'b0;
  int   monState = 0, pos = 0, preCnt = 0, frames = 0;
  int   oeBad = 0, mdcBad = 0, mdcBadMark = 0;
  logic [1:0]  mOp = '0, mTa = '0;
  logic [4:0]  mPhy = '0, mRg = '0;
  logic [15:0] mData = '0;
  logic        lineBit, expOe;

  task automatic frameEnd();
    frm_t e;
    if (expQ.size() > 0) e = expQ.pop_front();
    else if (scanOn) e = scanExp;
    else begin
      check("R8 unexpected extra frame", 1, 0);
      return;
    end
    check(curPre == 0 ? "R5 preamble length" : "R4 preamble length", preCnt, 32'(e.preLen));
    check(e.isRead ? "R6 read opcode" : "R4 write opcode", mOp, e.isRead ? 2'b10 : 2'b01);
    check("R4 PHY address field", mPhy, e.phy);
    check("R4 register address field", mRg, e.rg);
    if (!e.isRead) begin
      check("R4 turnaround bits", mTa, 2'b10);
      check("R4 write data bits", mData, e.data);
      if (mPhy == PHY_ID) phyMem[mRg] = mData;
    end
    check(e.isRead ? "R6 drive enable window" : "R4 drive enable window", oeBad, 0);
    check("R3 MDC half periods in frame", mdcBad - mdcBadMark, 0);
    oeBad = 0;
    mdcBadMark = mdcBad;
    frames++;
  endtask

  always @(posedge mdc) begin
    lineBit = mdioIn;
    case (monState)
      0: begin
        if (mdioOe !== 1'b1) oeBad++;
        if (lineBit) preCnt++;
        else monState = 1;
      end
      1: begin
        if (mdioOe !== 1'b1) oeBad++;
        if (lineBit) begin
          monState = 2; pos = 0; mOp = '0;
        end else begin
          check("R4 start pattern", 0, 1);
          monState = 0; preCnt = 0;
        end
      end
      default: begin
        expOe = !(mOp == 2'b10 && pos >= 12);
        if (mdioOe !== expOe) oeBad++;
        if (pos < 2)       mOp   = {mOp[0], lineBit};
        else if (pos < 7)  mPhy  = {mPhy[3:0], lineBit};
        else if (pos < 12) mRg   = {mRg[3:0], lineBit};
        else if (pos < 14) mTa   = {mTa[0], lineBit};
        else               mData = {mData[14:0], lineBit};
        pos++;
        if (pos == 30) begin
          frameEnd();
          monState = 0;
          preCnt = 0;
        end
      end
    endcase
  end

  always @(negedge mdc) begin
    if (monState == 2 && mOp == 2'b10 && pos >= 14 && pos <= 29)
      phyDrive = (mPhy == PHY_ID) ? phyMem[mRg][29-pos] : 1'b1;
    else
      phyDrive = 1'b1;
  end

  // MDC run-length monitor (R3)
  logic lastMdc = 1'b0;
  int   runLen = 0;
  always @(negedge clk) begin
    if (mdc === lastMdc) runLen++;
    else begin
      if (lastMdc && runLen != curHalf) mdcBad++;
      if (!lastMdc && monState == 2 && runLen != curHalf) mdcBad++;
      runLen = 1;
      lastMdc = mdc;
    end
  end

  // bus driver tasks
  task automatic busWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic setMode(logic [31:0] v);
    busWrite(SEL_MODE, v);
    curHalf = (v[7:1] == 7'd0) ? 1 : int'(v[7:1]);
    curPre  = v[8] ? 0 : 32;
  endtask

  task automatic waitIdle(string tag);
    logic [31:0] s;
    int n;
    n = 0;
    do begin busRead(SEL_STAT, s); n++; end while (s[1] && n < 20000);
    check(tag, 32'(s[1]), 0);
  endtask

  task automatic doFrame(logic isRead, logic [4:0] phy, logic [4:0] rg, logic [15:0] data);
    logic [31:0] s;
    frm_t e;
    e.isRead = isRead; e.phy = phy; e.rg = rg; e.data = data; e.preLen = 6'(curPre);
    busWrite(SEL_ADDR, {19'd0, rg, 3'd0, phy});
    if (!isRead) busWrite(SEL_TXD, {16'd0, data});
    expQ.push_back(e);
    busWrite(SEL_CMD, isRead ? 32'd2 : 32'd4);
    busRead(SEL_STAT, s);
    check("R7 busy set after command", 32'(s[1]), 1);
    waitIdle("R7 busy clears at frame end");
    busWrite(SEL_CMD, 32'd0);
  endtask

  // watchdog
  int cyc = 0;
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r, s, rxBefore;
    int f0, n;
    bit busyHeld;
    for (int i = 0; i < 32; i++) phyMem[i] = 16'(i * 16'h1111) ^ 16'h0F00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    for (int a = 0; a < 6; a++) begin
      busRead(3'(a), r);
      check("R1 register reset value", r, 0);
    end
    check("R1 MDC low after reset", 32'(mdc), 0);
    check("R1 drive enable low after reset", 32'(mdioOe), 0);

    // R2 mode field layout
    busWrite(SEL_MODE, 32'h1FF);
    busRead(SEL_MODE, r);
    check("R2 divider bit0 forced zero", r, 32'h1FE);
    setMode(32'h004);
    busRead(SEL_MODE, r);
    check("R2 mode readback", r, 32'h004);

    // R4 write frame
    doFrame(1'b0, PHY_ID, 5'd5, 16'hA5C3);
    check("R4 PHY register written", 32'(phyMem[5]), 32'hA5C3);

    // R6 read frame
    doFrame(1'b1, PHY_ID, 5'd5, 16'h0);
    busRead(SEL_RXD, r);
    check("R6 read data returned", r, 32'hA5C3);

    // R3 divider zero acts as two
    setMode(32'h000);
    doFrame(1'b1, PHY_ID, 5'd9, 16'h0);
    busRead(SEL_RXD, r);
    check("R3 read with divider zero", r, 32'(phyMem[9]));

    // R5 no preamble, divider 6
    setMode(32'h106);
    doFrame(1'b0, PHY_ID, 5'd7, 16'h0F0F);
    doFrame(1'b1, PHY_ID, 5'd7, 16'h0);
    busRead(SEL_RXD, r);
    check("R5 read without preamble", r, 32'h0F0F);

    // R6 absent PHY reads all ones
    doFrame(1'b1, 5'd9, 5'd2, 16'h0);
    busRead(SEL_RXD, r);
    check("R6 absent PHY returns ones", r, 32'hFFFF);

    // R8 command and register writes while busy
    setMode(32'h004);
    busRead(SEL_RXD, rxBefore);
    begin
      frm_t e;
      e.isRead = 1'b0; e.phy = PHY_ID; e.rg = 5'd12; e.data = 16'h3C3C; e.preLen = 6'(curPre);
      busWrite(SEL_ADDR, {19'd0, 5'd12, 3'd0, PHY_ID});
      busWrite(SEL_TXD, 32'h3C3C);
      expQ.push_back(e);
    end
    f0 = frames;
    busWrite(SEL_CMD, 32'd4);
    repeat (20) @(negedge clk);
    busWrite(SEL_ADDR, {19'd0, 5'd2, 3'd0, PHY_ID});
    busWrite(SEL_TXD, 32'h1111);
    busWrite(SEL_CMD, 32'd2);
    waitIdle("R8 busy clears after single frame");
    repeat (400) @(negedge clk);
    busRead(SEL_STAT, s);
    check("R8 no frame after ignored command busy", 32'(s[1]), 0);
    check("R8 exactly one frame", frames - f0, 1);
    check("R8 in-flight data kept", 32'(phyMem[12]), 32'h3C3C);
    busRead(SEL_RXD, r);
    check("R8 receive data untouched", r, rxBefore);
    busWrite(SEL_CMD, 32'd0);

    // R9 and R10 scan
    phyMem[1] = 16'h0000;
    busWrite(SEL_ADDR, {19'd0, 5'd1, 3'd0, PHY_ID});
    scanExp.isRead = 1'b1; scanExp.phy = PHY_ID; scanExp.rg = 5'd1;
    scanExp.data = 16'h0; scanExp.preLen = 6'(curPre);
    scanOn = 1'b1;
    busWrite(SEL_CMD, 32'd1);
    busRead(SEL_STAT, s);
    check("R10 invalid set at scan start", 32'(s[2]), 1);
    check("R9 busy during scan", 32'(s[1]), 1);
    busyHeld = 1'b1;
    n = 0;
    do begin busRead(SEL_STAT, s); if (!s[1]) busyHeld = 1'b0; n++; end
      while (s[2] && n < 5000);
    check("R10 invalid clears after first scan read", 32'(s[2]), 0);
    check("R10 link fail from bit2 clear", 32'(s[0]), 1);
    phyMem[1] = 16'h0004;
    f0 = frames;
    n = 0;
    do begin busRead(SEL_STAT, s); if (!s[1]) busyHeld = 1'b0; n++; end
      while (frames < f0 + 2 && n < 5000);
    repeat (10) @(negedge clk);
    busRead(SEL_STAT, s);
    check("R10 link fail from bit2 set", 32'(s[0]), 0);
    busRead(SEL_RXD, r);
    check("R9 scan updates receive data", r, 32'h0004);
    check("R9 busy held between scan frames", 32'(busyHeld), 1);
    busWrite(SEL_CMD, 32'd0);
    waitIdle("R9 busy drops after scan stop");
    f0 = frames;
    repeat (400) @(negedge clk);
    check("R9 no frames after scan stop", frames - f0, 0);
    scanOn = 1'b0;

    check("R3 MDC run lengths overall", mdcBad, 0);
    check("R4 no expected frames left", expQ.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule